// File: doc/BRIEF.md
# SDRAM Power-Up and Refresh Sequencer

This block sits on the controller side of a synchronous DRAM interface. It owns the command pins from reset. It holds the device in a quiet state for the required power-up pause, then closes all banks, runs a burst of auto-refresh commands and loads the mode register. After that it hands the bus to the rest of the controller by raising `ready`.

In normal operation an interval timer builds up a count of owed refreshes. While any refresh is owed, or while a refresh sequence is running, the sequencer raises `ref_req`. The controller answers with `ref_gnt` and keeps off the pins for as long as both are high. If the controller reports an open bank, the sequencer first issues precharge-all and then issues the refresh. Every time interval is given in nanoseconds and converted to clock counts from the clock period parameter. Gaps round up and the refresh interval rounds down.

Commands are encoded on `{cs_n, ras_n, cas_n, we_n}` as follows:

| Command | Encoding |
|---|---|
| NOP | 0111 |
| precharge-all | 0010 |
| auto-refresh | 0001 |
| mode-register write | 0000 |

Top module: `sdr_init_refresh`

## Requirements
- R1: During reset, and for INIT_CYC = ceil(INIT_WAIT_NS/clock period) cycles after reset is released, the pins carry NOP with `sd_cke` high and every `sd_dqm` bit high; `ready` and `ref_req` stay low until initialization ends.
- R2: The first command is precharge-all (code 0010 with `sd_addr[10]`=1, all other address bits 0, bank 0), issued exactly INIT_CYC cycles after reset release.
- R3: Exactly eight auto-refresh commands (code 0001, `sd_cke` high) follow. The first comes TRP_CYC cycles after the precharge, and each later one comes TRC_CYC cycles after the one before.
- R4: The mode-register write (code 0000, bank 0) follows TRC_CYC cycles after the last initialization refresh. Its address carries the burst-length code in bits 2:0, the interleave flag in bit 3, the CAS-latency code in bits 6:4 and the single-write flag in bit 9, with all other bits 0.
- R5: `ready` rises exactly 2 cycles after the mode-register write, with only NOP in between. It then stays high, and `sd_dqm` drops to 0 once `ready` is high.
- R6: Once ready, one refresh becomes owed every REFI_CYC cycles, counted from the first ready cycle. `ref_req` is high whenever a refresh is owed or a refresh sequence is running.
- R7: No command is issued while a refresh is owed and `ref_gnt` is low.
- R8: When a refresh is granted while `banks_open` is high, precharge-all is issued on the next cycle and auto-refresh TRP_CYC cycles later.
- R9: When a refresh is granted while `banks_open` is low, auto-refresh is issued on the next cycle.
- R10: The bus returns TRC_CYC cycles after a refresh, and `ref_req` drops at that point if nothing more is owed. Owed refreshes that have piled up are issued TRC_CYC+1 cycles apart.
- R11: Command gaps are rounded up to whole cycles with a minimum of 2, and the refresh interval is rounded down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_burst_len | input | 3 | Burst-length code for the mode word |
| cfg_interleave | input | 1 | Interleaved burst order when 1 |
| cfg_cas_lat | input | 3 | CAS-latency code (010 = 2, 011 = 3) |
| cfg_single_write | input | 1 | Burst read with single-word write when 1 |
| banks_open | input | 1 | Controller reports at least one open bank |
| ref_gnt | input | 1 | Controller yields the pins to the sequencer |
| ref_req | output | 1 | Refresh owed or in progress |
| ready | output | 1 | Initialization complete |
| sd_cke | output | 1 | Clock enable |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_dqm | output | DQM_W | Data mask |
| sd_addr | output | ADDR_W | Address bus |
| sd_ba | output | BANK_W | Bank address |

## Verification
The bench builds the block with a 4000 ps clock and these intervals:

| Parameter | Value | Cycles |
|---|---|---|
| INIT_WAIT_NS | 1999 | 500 |
| TRP_NS | 18 | 5 |
| TRC_NS | 57 | 15 |
| REFI_NS | 402 | 100 |

These values make the rounding in both directions visible, and they keep the whole power-up sequence and several refresh intervals within a few thousand cycles. With a short interval the bench can let two refreshes pile up under a withheld grant. It can then watch the precharge-first path, the back-to-back path and the plain refresh path, each at an exact predicted cycle.

// File: rtl/sdr_seq_pkg.sv
package sdr_seq_pkg;

    // {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_MRS  = 4'b0000,
        CMD_REF  = 4'b0001,
        CMD_PALL = 4'b0010,
        CMD_NOP  = 4'b0111
    } sdr_cmd_e;

    typedef enum logic [3:0] {
        S_WAIT, S_IPRE, S_IPRE_W, S_IREF, S_IREF_W, S_MRS, S_MRS_W,
        S_IDLE, S_RPRE, S_RPRE_W, S_RREF, S_RREF_W
    } seq_state_e;

    typedef struct packed {
        logic [2:0] burst_len;
        logic       interleave;
        logic [2:0] cas_lat;
        logic       single_write;
    } mode_cfg_t;

    // R11: gaps round up, intervals round down
    function automatic int unsigned ns_to_cyc_up(int unsigned ns, int unsigned clk_ps);
        return (ns * 1000 + clk_ps - 1) / clk_ps;
    endfunction

    function automatic int unsigned ns_to_cyc_down(int unsigned ns, int unsigned clk_ps);
        return (ns * 1000) / clk_ps;
    endfunction

    function automatic int unsigned gap_floor(int unsigned cyc);
        return (cyc < 2) ? 2 : cyc;
    endfunction

    function automatic logic [11:0] mode_word(mode_cfg_t c);
        logic [11:0] w;
        w      = '0;
        w[2:0] = c.burst_len;
        w[3]   = c.interleave;
        w[6:4] = c.cas_lat;
        w[9]   = c.single_write;
        return w;
    endfunction

endpackage

// File: rtl/sdr_gap_counter.sv
module sdr_gap_counter #(
    parameter int W       = 16,
    parameter int RST_VAL = 0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)               cnt <= W'(RST_VAL);
        else if (load)         cnt <= load_val;
        else if (cnt != '0)    cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);

    p_load_counts_r11: assert property (@(posedge clk) disable iff (rst)
        load |=> (cnt == $past(load_val)));
endmodule

// File: rtl/sdr_refi_timer.sv
module sdr_refi_timer #(
    parameter int PERIOD   = 3906,
    parameter int MAX_OWED = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic take,
    output logic pending
);
    localparam int TW = $clog2(PERIOD + 1);
    localparam int OW = $clog2(MAX_OWED + 1);

    logic [TW-1:0] tmr;
    logic [OW-1:0] owed;
    logic          tick;

    assign tick = en && (tmr == '0);

    always_ff @(posedge clk) begin
        if (rst)       tmr <= TW'(PERIOD - 1);
        else if (tick) tmr <= TW'(PERIOD - 1);
        else if (en)   tmr <= tmr - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            owed <= '0;
        end else begin
            case ({tick && (owed != OW'(MAX_OWED)), take})
                2'b10:   owed <= owed + 1'b1;
                2'b01:   owed <= owed - 1'b1;
                default: owed <= owed;
            endcase
        end
    end

    assign pending = (owed != '0);

    p_owed_bound_r6: assert property (@(posedge clk) disable iff (rst)
        owed <= OW'(MAX_OWED));
    p_take_needs_owed_r10: assert property (@(posedge clk) disable iff (rst)
        take |-> (owed != '0));
endmodule

// File: rtl/sdr_init_refresh.sv
module sdr_init_refresh
    import sdr_seq_pkg::*;
#(
    parameter int CLK_PS       = 4000,
    parameter int INIT_WAIT_NS = 200000,
    parameter int TRP_NS       = 20,
    parameter int TRC_NS       = 60,
    parameter int REFI_NS      = 15625,
    parameter int INIT_REFS    = 8,
    parameter int MRS_GAP      = 2,
    parameter int MAX_OWED     = 8,
    parameter int ADDR_W       = 12,
    parameter int BANK_W       = 2,
    parameter int DQM_W        = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        cfg_burst_len,
    input  logic              cfg_interleave,
    input  logic [2:0]        cfg_cas_lat,
    input  logic              cfg_single_write,
    input  logic              banks_open,
    input  logic              ref_gnt,
    output logic              ref_req,
    output logic              ready,
    output logic              sd_cke,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [DQM_W-1:0]  sd_dqm,
    output logic [ADDR_W-1:0] sd_addr,
    output logic [BANK_W-1:0] sd_ba
);
    localparam int INIT_CYC = ns_to_cyc_up(INIT_WAIT_NS, CLK_PS);
    localparam int TRP_CYC  = gap_floor(ns_to_cyc_up(TRP_NS, CLK_PS));
    localparam int TRC_CYC  = gap_floor(ns_to_cyc_up(TRC_NS, CLK_PS));
    localparam int REFI_CYC = ns_to_cyc_down(REFI_NS, CLK_PS);
    localparam int CW       = $clog2(INIT_CYC + TRC_CYC + TRP_CYC + 1);
    localparam int IRW      = $clog2(INIT_REFS + 1);

    seq_state_e     state, nxt;
    sdr_cmd_e       cmd;
    logic           g_load, g_done, ready_q, pending, take;
    logic [CW-1:0]  g_val;
    logic [IRW-1:0] ir_cnt;
    mode_cfg_t      cfg;

    assign cfg = '{burst_len: cfg_burst_len, interleave: cfg_interleave,
                   cas_lat: cfg_cas_lat, single_write: cfg_single_write};

    sdr_gap_counter #(.W(CW), .RST_VAL(INIT_CYC - 1)) gap_i (
        .clk(clk), .rst(rst), .load(g_load), .load_val(g_val), .done(g_done));

    sdr_refi_timer #(.PERIOD(REFI_CYC), .MAX_OWED(MAX_OWED)) refi_i (
        .clk(clk), .rst(rst), .en(ready_q), .take(take), .pending(pending));

    always_comb begin
        nxt    = state;
        g_load = 1'b0;
        g_val  = '0;
        unique case (state)
            S_WAIT:   if (g_done) nxt = S_IPRE;
            S_IPRE:   begin g_load = 1'b1; g_val = CW'(TRP_CYC - 2); nxt = S_IPRE_W; end
            S_IPRE_W: if (g_done) nxt = S_IREF;
            S_IREF:   begin g_load = 1'b1; g_val = CW'(TRC_CYC - 2); nxt = S_IREF_W; end
            S_IREF_W: if (g_done) nxt = (ir_cnt == IRW'(INIT_REFS)) ? S_MRS : S_IREF;
            S_MRS:    begin g_load = 1'b1; g_val = CW'(MRS_GAP - 2); nxt = S_MRS_W; end
            S_MRS_W:  if (g_done) nxt = S_IDLE;
            S_IDLE:   if (pending && ref_gnt) nxt = banks_open ? S_RPRE : S_RREF;
            S_RPRE:   begin g_load = 1'b1; g_val = CW'(TRP_CYC - 2); nxt = S_RPRE_W; end
            S_RPRE_W: if (g_done) nxt = S_RREF;
            S_RREF:   begin g_load = 1'b1; g_val = CW'(TRC_CYC - 2); nxt = S_RREF_W; end
            S_RREF_W: if (g_done) nxt = S_IDLE;
            default:  nxt = S_WAIT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= S_WAIT;
            ir_cnt  <= '0;
            ready_q <= 1'b0;
        end else begin
            state <= nxt;
            if (state == S_IREF)                ir_cnt  <= ir_cnt + 1'b1;
            if (state == S_MRS_W && g_done)     ready_q <= 1'b1;
        end
    end

    assign take = (state == S_RREF);

    always_comb begin
        sd_addr = '0;
        unique case (state)
            S_IPRE, S_RPRE: begin cmd = CMD_PALL; sd_addr[10] = 1'b1; end
            S_IREF, S_RREF: cmd = CMD_REF;
            S_MRS:          begin cmd = CMD_MRS; sd_addr[11:0] = mode_word(cfg); end
            default:        cmd = CMD_NOP;
        endcase
    end

    assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;
    assign sd_cke  = 1'b1;
    assign sd_ba   = '0;
    assign sd_dqm  = ready_q ? '0 : '1;
    assign ready   = ready_q;
    assign ref_req = ready_q && (pending || state == S_RPRE || state == S_RPRE_W ||
                                 state == S_RREF || state == S_RREF_W);

    // spacing watchers for the assertions below
    logic [CW-1:0] since_ref, since_pre;
    always_ff @(posedge clk) begin
        if (rst) begin
            since_ref <= CW'(TRC_CYC);
            since_pre <= CW'(TRP_CYC);
        end else begin
            if (cmd == CMD_REF)              since_ref <= CW'(1);
            else if (since_ref != CW'(TRC_CYC)) since_ref <= since_ref + 1'b1;
            if (cmd == CMD_PALL)             since_pre <= CW'(1);
            else if (since_pre != CW'(TRP_CYC)) since_pre <= since_pre + 1'b1;
        end
    end

    p_ref_spacing_r10: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_REF) |-> (since_ref >= CW'(TRC_CYC)));
    p_pre_gap_r8: assert property (@(posedge clk) disable iff (rst)
        (cmd != CMD_NOP && cmd != CMD_PALL) |-> (since_pre >= CW'(TRP_CYC)));
    p_mrs_then_nop_r5: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_MRS) |=> (cmd == CMD_NOP));
    p_ready_hold_r5: assert property (@(posedge clk) disable iff (rst)
        ready_q |=> ready_q);
    p_no_grant_no_cmd_r7: assert property (@(posedge clk) disable iff (rst)
        (state == S_IDLE && !ref_gnt) |=> (cmd == CMD_NOP));
endmodule

// File: tb/sdr_init_refresh_tb.sv
module sdr_init_refresh_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic banks_open = 1'b0, ref_gnt = 1'b0;
    logic ref_req, ready, sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
    logic [1:0]  sd_dqm, sd_ba;
    logic [11:0] sd_addr;

    always #2 clk = ~clk;   // 250 MHz

    sdr_init_refresh #(.CLK_PS(4000), .INIT_WAIT_NS(1999), .TRP_NS(18),
                       .TRC_NS(57), .REFI_NS(402)) dut_i (
        .clk(clk), .rst(rst), .cfg_burst_len(3'b011), .cfg_interleave(1'b1),
        .cfg_cas_lat(3'b010), .cfg_single_write(1'b1), .banks_open(banks_open),
        .ref_gnt(ref_gnt), .ref_req(ref_req), .ready(ready), .sd_cke(sd_cke),
        .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
        .sd_we_n(sd_we_n), .sd_dqm(sd_dqm), .sd_addr(sd_addr), .sd_ba(sd_ba));

    typedef struct {
        logic [3:0]  cmd;
        logic [11:0] addr;
        int          cyc;
        string       tag;
    } exp_t;
    exp_t q[$];

    int  cyc = 0, nchk = 0, nfail = 0;
    bit  finished = 0, init_bad = 0;

    always @(posedge clk) cyc <= rst ? 0 : cyc + 1;

    task automatic check(bit ok, string req, string what, int act, int expv);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    task automatic push_exp(logic [3:0] c, logic [11:0] a, int at, string tag);
        exp_t e;
        e.cmd = c; e.addr = a; e.cyc = at; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic wait_cyc(int n);
        while (cyc < n) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    endtask

    // monitor: pops one expected command per non-NOP command on the pins
    always @(negedge clk) begin
        logic [3:0] c;
        exp_t e;
        if (!rst && !finished) begin
            c = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
            if (!ready && (sd_cke !== 1'b1 || sd_dqm !== 2'b11)) init_bad = 1;
            if (c != 4'b0111) begin
                if (q.size() == 0) begin
                    check(0, "R7", "unexpected command", int'(c), 4'h7);
                end else begin
                    e = q.pop_front();
                    check(c == e.cmd && sd_addr == e.addr && sd_ba == 2'b00 && sd_cke,
                          e.tag, "command/address", int'({c, sd_addr}), int'({e.cmd, e.addr}));
                    check(cyc == e.cyc, e.tag, "issue cycle", cyc, e.cyc);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        check(0, "R1", "watchdog expired", cyc, 0);
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state
        check(sd_cke && sd_dqm == 2'b11 && {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0111,
              "R1", "pins in reset", int'({sd_cke, sd_dqm, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}), 8'h77);
        check(!ready && !ref_req, "R1", "ready/ref_req in reset", int'({ready, ref_req}), 0);

        // R2/R11: precharge-all at 500 (1999 ns rounded up)
        push_exp(4'b0010, 12'h400, 500, "R2");
        // R3: eight refreshes, first at +5 (18 ns up), then +15 (57 ns up)
        for (int k = 0; k < 8; k++) push_exp(4'b0001, 12'h000, 505 + 15 * k, "R3");
        // R4: mode word 0x22B = single write, CL code 010, interleave, BL code 011
        push_exp(4'b0000, 12'h22B, 625, "R4");
        @(negedge clk);
        rst = 1'b0;

        wait_cyc(626);
        check(!ready, "R5", "ready before MRS+2", int'(ready), 0);
        wait_cyc(627);
        check(ready, "R5", "ready at MRS+2", int'(ready), 1);
        check(sd_dqm == 2'b00, "R5", "dqm after ready", int'(sd_dqm), 0);
        check(!init_bad, "R1", "cke/dqm high during init", int'(init_bad), 0);

        // R6: first owed refresh after 100 cycles (402 ns rounded down)
        wait_cyc(726);
        check(!ref_req, "R6", "ref_req before interval", int'(ref_req), 0);
        wait_cyc(727);
        check(ref_req, "R6", "ref_req at interval", int'(ref_req), 1);

        // R7: grant withheld until two refreshes are owed; no command meanwhile
        push_exp(4'b0010, 12'h400, 831, "R8");
        push_exp(4'b0001, 12'h000, 836, "R8");
        push_exp(4'b0001, 12'h000, 852, "R10");
        push_exp(4'b0001, 12'h000, 928, "R9");
        wait_cyc(830);
        check(q.size() == 4, "R7", "no command without grant", q.size(), 4);
        ref_gnt = 1'b1;
        banks_open = 1'b1;
        wait_cyc(831);
        banks_open = 1'b0;

        wait_cyc(866);
        check(ref_req, "R10", "ref_req during tRC", int'(ref_req), 1);
        wait_cyc(867);
        check(!ref_req, "R10", "ref_req drops at REF+tRC", int'(ref_req), 0);

        wait_cyc(950);
        check(q.size() == 0, "R9", "all expected commands seen", q.size(), 0);
        check(ready, "R5", "ready still high", int'(ready), 1);
        finish_run();
    end
endmodule